// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit with Selectable NaN Handling

This block returns the smaller or larger of two single-precision (binary32) values. Three NaN policies can be selected with each operation. The number-favouring policy discards a lone NaN. The NaN-favouring policy lets any NaN win and carries its payload. The maximumNumber policy discards a lone NaN and treats a pair of NaNs the way an ordinary arithmetic operation does. Any NaN the block emits is quiet. A quieted NaN keeps its sign and its lower payload bits, so a canonical NaN input always comes back as exactly the canonical pattern.

The datapath is a short chain: operand classification, a sign-magnitude ordering network and a result multiplexer. The result is registered, so it appears one clock after the inputs are presented with the valid strobe. The invalid flag travels with that result. It reports whether either operand was a signalling NaN.

Top module: `fp_minmax_sel`

## Requirements
- R1: After reset, `res_valid` is 0.
- R2: For two non-NaN operands, `pick_max`=0 returns the smaller and `pick_max`=1 returns the larger, using sign-magnitude ordering (a set bit 31 is negative, bits 30:23 are the exponent and bits 22:0 are the significand).
- R3: When the two numeric operands compare equal, `src1` is returned. In modes 0 and 2, +0 and -0 compare equal.
- R4: In mode 1 (NaN-favouring; mode 3 behaves the same), -0 orders strictly below +0, whatever the operand order.
- R5: In mode 0 (number-favouring), a single NaN operand, whether quiet or signalling, yields the other operand unchanged.
- R6: In modes 0 and 2, two NaN operands yield the quieted `src1`. Quieting sets bit 22 and keeps all other bits.
- R7: In modes 1 and 3, a NaN `src1` yields the quieted `src1`. If only `src2` is NaN, the result is the quieted `src2`.
- R8: In mode 2 (maximumNumber), a single NaN yields the numeric operand.
- R9: When every NaN input is 0x7FC00000, a NaN result is exactly 0x7FC00000.
- R10: `invalid` is 1 exactly when an operand is a signalling NaN (exponent all ones, bit 22 clear, significand nonzero), in every mode. A quiet NaN leaves it 0.
- R11: `res_valid` follows `in_valid` by one cycle. `result` holds its value while no operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| src1 | input | 32 | First operand, binary32 |
| src2 | input | 32 | Second operand, binary32 |
| pick_max | input | 1 | 1 = maximum, 0 = minimum |
| nan_mode | input | 2 | 0 number-favouring, 1/3 NaN-favouring, 2 maximumNumber |
| res_valid | output | 1 | Result valid |
| result | output | 32 | Selected or quieted value |
| invalid | output | 1 | A signalling NaN was an operand |

## Verification
Every result, its invalid flag and its valid strobe are due on the first rising edge after the operands are presented. The bench drives inputs on a falling edge and samples one full cycle later, on the following falling edge. To check that the result is held, the bench removes the valid strobe and samples one more cycle later. At that point the output must show the previous value and a low strobe.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } opcls_t;

  typedef enum logic [1:0] {
    MODE_NUM   = 2'd0,
    MODE_NAN   = 2'd1,
    MODE_MAXN  = 2'd2,
    MODE_NAN_B = 2'd3
  } nan_mode_e;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] value,
  output opcls_t       cls
);
  logic exp_ones, man_nz;

  always_comb begin
    exp_ones    = &value[W-2:MAN_W];
    man_nz      = |value[MAN_W-1:0];
    cls.is_nan  = exp_ones && man_nz;
    cls.is_snan = exp_ones && man_nz && !value[MAN_W-1];
    cls.is_zero = ~|value[W-2:0];
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         a_zero,
  input  logic         b_zero,
  input  logic         signed_zero,
  output logic         a_lt_b,
  output logic         b_lt_a
);
  logic mag_lt, mag_gt, both_zero;

  always_comb begin
    mag_lt    = a[W-2:0] < b[W-2:0];
    mag_gt    = a[W-2:0] > b[W-2:0];
    both_zero = a_zero && b_zero;
    a_lt_b    = 1'b0;
    b_lt_a    = 1'b0;
    if (both_zero) begin
      if (signed_zero) begin
        a_lt_b = a[W-1] && !b[W-1];
        b_lt_a = b[W-1] && !a[W-1];
      end
    end else if (a[W-1] != b[W-1]) begin
      a_lt_b = a[W-1];
      b_lt_a = b[W-1];
    end else if (!a[W-1]) begin
      a_lt_b = mag_lt;
      b_lt_a = mag_gt;
    end else begin
      a_lt_b = mag_gt;
      b_lt_a = mag_lt;
    end
  end
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  opcls_t       a_cls,
  input  opcls_t       b_cls,
  input  logic         nan_prop,
  input  logic         pick_max,
  input  logic         a_lt_b,
  input  logic         b_lt_a,
  output logic [W-1:0] sel
);
  localparam logic [W-1:0] QBIT = W'(1) << (MAN_W - 1);
  logic [W-1:0] a_q, b_q;
  logic         take_a;

  always_comb begin
    a_q    = a | QBIT;
    b_q    = b | QBIT;
    take_a = pick_max ? !a_lt_b : !b_lt_a;
    if (nan_prop && a_cls.is_nan)      sel = a_q;
    else if (nan_prop && b_cls.is_nan) sel = b_q;
    else if (a_cls.is_nan && b_cls.is_nan) sel = a_q;
    else if (a_cls.is_nan)             sel = b;
    else if (b_cls.is_nan)             sel = a;
    else                               sel = take_a ? a : b;
  end
endmodule

// File: rtl/fp_minmax_sel.sv
module fp_minmax_sel
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] src1,
  input  logic [W-1:0] src2,
  input  logic         pick_max,
  input  logic [1:0]   nan_mode,
  output logic         res_valid,
  output logic [W-1:0] result,
  output logic         invalid
);
  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0] opnd [2];
  opcls_t       cls  [2];
  logic         nan_prop, a_lt_b, b_lt_a;
  logic [W-1:0] sel_d, res_q;
  logic         vld_d, vld_q, inv_d, inv_q;

  assign opnd[0] = src1;
  assign opnd[1] = src2;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .value(opnd[i]),
      .cls  (cls[i])
    );
  end

  assign nan_prop = (nan_mode == MODE_NAN) || (nan_mode == MODE_NAN_B);

  fpmm_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ord (
    .a          (src1),
    .b          (src2),
    .a_zero     (cls[0].is_zero),
    .b_zero     (cls[1].is_zero),
    .signed_zero(nan_prop),
    .a_lt_b     (a_lt_b),
    .b_lt_a     (b_lt_a)
  );

  fpmm_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
    .a       (src1),
    .b       (src2),
    .a_cls   (cls[0]),
    .b_cls   (cls[1]),
    .nan_prop(nan_prop),
    .pick_max(pick_max),
    .a_lt_b  (a_lt_b),
    .b_lt_a  (b_lt_a),
    .sel     (sel_d)
  );

  always_comb begin
    vld_d = in_valid;
    inv_d = in_valid ? (cls[0].is_snan || cls[1].is_snan) : inv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      inv_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      inv_q <= inv_d;
      if (in_valid) res_q <= sel_d;
    end
  end

  assign res_valid = vld_q;
  assign result    = res_q;
  assign invalid   = inv_q;

  assert_valid_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(in_valid));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_snan_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> invalid == ($past(cls[0].is_snan) || $past(cls[1].is_snan)));
  assert_canon_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (cls[0].is_nan || cls[1].is_nan)
      && (!cls[0].is_nan || src1 == CANON) && (!cls[1].is_nan || src2 == CANON)
      |=> (&result[W-2:MAN_W] && |result[MAN_W-1:0]) -> result == CANON);
  assert_quiet_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cls[0].is_nan && cls[1].is_nan |=> result[MAN_W-1]);
  assert_num_pref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !nan_prop && cls[0].is_nan && !cls[1].is_nan |=> result == $past(src2));
endmodule

// File: tb/tb_fp_minmax_sel.sv
module tb_fp_minmax_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src1 = '0, src2 = '0;
  logic        pick_max = 1'b0;
  logic [1:0]  nan_mode = 2'd0;
  logic        res_valid, invalid;
  logic [31:0] result;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  fp_minmax_sel dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src1(src1), .src2(src2),
    .pick_max(pick_max), .nan_mode(nan_mode), .res_valid(res_valid),
    .result(result), .invalid(invalid)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic op(input string req, input logic [1:0] m, input logic mx,
                    input logic [31:0] a, input logic [31:0] b,
                    input logic [31:0] exp_r, input logic exp_inv);
    @(negedge clk);
    in_valid = 1'b1; nan_mode = m; pick_max = mx; src1 = a; src2 = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, result, exp_r);
    check({req, " invalid"}, {31'd0, invalid}, {31'd0, exp_inv});
    check({req, " valid"}, {31'd0, res_valid}, 32'd1);
  endtask

  task automatic t_reset_r1;
    check("R1 reset valid", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_order_r2;
    op("R2 min pos", 2'd0, 1'b0, 32'h3F800000, 32'h40000000, 32'h3F800000, 1'b0);
    op("R2 max neg", 2'd0, 1'b1, 32'hBF800000, 32'hC0000000, 32'hBF800000, 1'b0);
    op("R2 max mixed", 2'd2, 1'b1, 32'hC0400000, 32'h3F000000, 32'h3F000000, 1'b0);
    op("R2 min neg", 2'd1, 1'b0, 32'h3F000000, 32'hC0400000, 32'hC0400000, 1'b0);
  endtask

  task automatic t_equal_r3;
    op("R3 max +0,-0", 2'd0, 1'b1, 32'h00000000, 32'h80000000, 32'h00000000, 1'b0);
    op("R3 min -0,+0", 2'd0, 1'b0, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0);
    op("R3 max -0,+0 m2", 2'd2, 1'b1, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0);
  endtask

  task automatic t_zero_r4;
    op("R4 min +0,-0", 2'd1, 1'b0, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0);
    op("R4 max -0,+0", 2'd1, 1'b1, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0);
    op("R4 max +0,-0 m3", 2'd3, 1'b1, 32'h00000000, 32'h80000000, 32'h00000000, 1'b0);
  endtask

  task automatic t_numpref_r5;
    op("R5 qnan,num", 2'd0, 1'b1, 32'h7FC00000, 32'h3F800000, 32'h3F800000, 1'b0);
    op("R5 num,snan", 2'd0, 1'b0, 32'h40000000, 32'h7F800001, 32'h40000000, 1'b1);
  endtask

  task automatic t_twonan_r6;
    op("R6 m0 two nan", 2'd0, 1'b1, 32'h7F800005, 32'h7FC00001, 32'h7FC00005, 1'b1);
    op("R6 m2 two nan", 2'd2, 1'b0, 32'hFFC00123, 32'h7F800002, 32'hFFC00123, 1'b1);
  endtask

  task automatic t_prop_r7;
    op("R7 num,snan", 2'd1, 1'b1, 32'h3F800000, 32'h7F800003, 32'h7FC00003, 1'b1);
    op("R7 two qnan", 2'd1, 1'b0, 32'h7FC00010, 32'h7FC00020, 32'h7FC00010, 1'b0);
    op("R7 snan,num m3", 2'd3, 1'b0, 32'hFF800007, 32'h00000000, 32'hFFC00007, 1'b1);
  endtask

  task automatic t_maxnum_r8;
    op("R8 num,qnan", 2'd2, 1'b1, 32'hC1200000, 32'h7FC00000, 32'hC1200000, 1'b0);
    op("R8 snan,num", 2'd2, 1'b0, 32'h7F800009, 32'h41200000, 32'h41200000, 1'b1);
  endtask

  task automatic t_canon_r9;
    op("R9 prop canon,num", 2'd1, 1'b0, 32'h40000000, 32'h7FC00000, 32'h7FC00000, 1'b0);
    op("R9 prop canon x2", 2'd1, 1'b1, 32'h7FC00000, 32'h7FC00000, 32'h7FC00000, 1'b0);
    op("R9 m0 canon x2", 2'd0, 1'b0, 32'h7FC00000, 32'h7FC00000, 32'h7FC00000, 1'b0);
  endtask

  task automatic t_flag_r10;
    op("R10 neg qnan", 2'd1, 1'b1, 32'hFFC00001, 32'h3F800000, 32'hFFC00001, 1'b0);
    op("R10 inf not nan", 2'd0, 1'b1, 32'h7F800000, 32'h3F800000, 32'h7F800000, 1'b0);
  endtask

  task automatic t_hold_r11;
    op("R11 load", 2'd0, 1'b1, 32'h42000000, 32'h41000000, 32'h42000000, 1'b0);
    @(negedge clk);
    src1 = 32'h00000001; src2 = 32'h7F800001;
    @(negedge clk);
    check("R11 valid low", {31'd0, res_valid}, 32'd0);
    check("R11 result held", result, 32'h42000000);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    t_order_r2();
    t_equal_r3();
    t_zero_r4();
    t_numpref_r5();
    t_twonan_r6();
    t_prop_r7();
    t_maxnum_r8();
    t_canon_r9();
    t_flag_r10();
    t_hold_r11();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule